// File: doc/BRIEF.md
# Instruction fetch bus unit

This block sits between a processor core's front end and its instruction memory. It fetches one 32-bit instruction word at a time over a read-only copy of the shared memory bus. That bus has two independent valid/ready handshakes: a request channel carrying address, direction, size, byte strobes, write data and an atomic-operation code, and a response channel carrying read data and a one-bit error flag. The unit keeps its own program counter. The counter is loaded with a reset vector and can be moved by a redirect from the core.

A one-cycle fetch-request pulse starts a fetch at the current program counter. If a redirect arrives in the same cycle, the fetch starts at the redirect target instead. The result is a one-cycle completion strobe. It carries either the fetched word or a trap flag with a cause code, together with the address of the fetch. A program counter that is not word aligned traps with cause 0, and no bus request is made. An error response traps with cause 1. A successful fetch advances the counter by four. A trapping fetch leaves the counter where it was. While a fetch is in progress, new fetch requests and redirects are ignored.

Top module: `ifetch_unit`

## Requirements
- R1: After reset the unit is idle (`busy`, `done_valid` and `ibus_req_valid` low), and a fetch with no redirect reads address `RESET_VEC` (default 0x0000_1000).
- R2: Every request handshake carries `ibus_req_we`=0, `ibus_req_amo`=0, `ibus_req_wstrb`=0, `ibus_req_wdata`=0 and `ibus_req_size`=2'b10 (word).
- R3: A request stays valid with a stable address until `ibus_req_ready` is seen high, and each fetch makes exactly one request handshake.
- R4: `ibus_rsp_ready` is high only after the request has been accepted and until the response arrives, and it is never high while `ibus_req_valid` is high. At most one fetch is in flight.
- R5: A response without error gives a one-cycle `done_valid` in the cycle after the response handshake, with `done_trap`=0, `done_instr` equal to the response data and `done_pc` equal to the fetch address. The next fetch with no redirect uses that address plus 4.
- R6: A fetch whose address has bits [1:0] not equal to 0 gives `done_valid` in the cycle after the fetch request, with `done_trap`=1 and `done_cause`=0, and makes no request handshake.
- R7: A response with `ibus_rsp_err`=1 gives `done_trap`=1, `done_cause`=1 and `done_pc` equal to the fetch address. The program counter does not advance, so the next fetch with no redirect uses the same address.
- R8: A redirect while idle sets the address of the next fetch. A redirect in the same cycle as a fetch request takes effect for that fetch. A redirect while `busy` is high has no effect.
- R9: A fetch request while `busy` is high is ignored. No extra request is made, and the unit is idle once the current fetch completes.
- R10: Results are correct for any request-ready delay and any response delay, including a request accepted in its first cycle and a response in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | One-cycle pulse that starts a fetch |
| redir_valid | input | 1 | Load a new program counter (used only when idle) |
| redir_pc | input | 32 | Redirect target address |
| busy | output | 1 | A fetch is in progress |
| ibus_req_valid | output | 1 | Request channel valid |
| ibus_req_ready | input | 1 | Request channel ready |
| ibus_req_addr | output | 32 | Byte address of the fetch |
| ibus_req_we | output | 1 | Write flag, always 0 |
| ibus_req_size | output | 2 | Access size, always word (2'b10) |
| ibus_req_wdata | output | 32 | Write data, always 0 |
| ibus_req_wstrb | output | 4 | Byte strobes, always 0 |
| ibus_req_amo | output | 4 | Atomic-op code, always 0 |
| ibus_rsp_valid | input | 1 | Response channel valid |
| ibus_rsp_ready | output | 1 | Response channel ready |
| ibus_rsp_rdata | input | 32 | Response read data |
| ibus_rsp_err | input | 1 | Response access error |
| done_valid | output | 1 | One-cycle completion strobe |
| done_trap | output | 1 | The fetch trapped |
| done_cause | output | CAUSE_W | Trap cause: 0 misaligned, 1 access fault |
| done_instr | output | 32 | Fetched word (0 on trap) |
| done_pc | output | 32 | Address of the completed fetch |

## Verification
The bench walks fetches through a slave model with different ready and response delays, zero-wait among them. It checks that a misaligned address traps at once with no bus traffic; a unit that issued the request anyway would show up in the handshake count. Error responses must give cause 1 and leave the counter in place, so a unit that advanced after a fault would retry the wrong address. A redirect and a second fetch request are driven while a slow fetch is outstanding. A unit that took either one would fetch from the wrong address next, or start a phantom second request.

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
  parameter logic [31:0] RESET_VEC = 32'h0000_1000,
  parameter int          CAUSE_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_req,
  input  logic               redir_valid,
  input  logic [31:0]        redir_pc,
  output logic               busy,
  output logic               ibus_req_valid,
  input  logic               ibus_req_ready,
  output logic [31:0]        ibus_req_addr,
  output logic               ibus_req_we,
  output logic [1:0]         ibus_req_size,
  output logic [31:0]        ibus_req_wdata,
  output logic [3:0]         ibus_req_wstrb,
  output logic [3:0]         ibus_req_amo,
  input  logic               ibus_rsp_valid,
  output logic               ibus_rsp_ready,
  input  logic [31:0]        ibus_rsp_rdata,
  input  logic               ibus_rsp_err,
  output logic               done_valid,
  output logic               done_trap,
  output logic [CAUSE_W-1:0] done_cause,
  output logic [31:0]        done_instr,
  output logic [31:0]        done_pc
);

  localparam logic [CAUSE_W-1:0] CAUSE_MISAL = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] CAUSE_FAULT = CAUSE_W'(1);
  localparam logic [1:0]         SIZE_WORD   = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} state_t;

  state_t      st;
  logic [31:0] pc_q;
  logic [31:0] pc_eff;
  logic        idle;
  logic        misal;

  assign idle   = (st == S_IDLE);
  assign pc_eff = redir_valid ? redir_pc : pc_q;
  assign misal  = (pc_eff[1:0] != 2'b00);

  assign busy           = !idle;
  assign ibus_req_valid = (st == S_REQ);
  assign ibus_rsp_ready = (st == S_RSP);
  assign ibus_req_addr  = pc_q;
  assign ibus_req_we    = 1'b0;
  assign ibus_req_size  = SIZE_WORD;
  assign ibus_req_wdata = '0;
  assign ibus_req_wstrb = '0;
  assign ibus_req_amo   = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pc_q       <= RESET_VEC;
      done_valid <= 1'b0;
      done_trap  <= 1'b0;
      done_cause <= '0;
      done_instr <= '0;
      done_pc    <= '0;
    end else begin
      done_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (redir_valid) pc_q <= redir_pc;
          if (fetch_req) begin
            if (misal) begin
              done_valid <= 1'b1;
              done_trap  <= 1'b1;
              done_cause <= CAUSE_MISAL;
              done_instr <= '0;
              done_pc    <= pc_eff;
            end else begin
              st <= S_REQ;
            end
          end
        end
        S_REQ: begin
          if (ibus_req_ready) st <= S_RSP;
        end
        S_RSP: begin
          if (ibus_rsp_valid) begin
            st         <= S_IDLE;
            done_valid <= 1'b1;
            done_pc    <= pc_q;
            if (ibus_rsp_err) begin
              done_trap  <= 1'b1;
              done_cause <= CAUSE_FAULT;
              done_instr <= '0;
            end else begin
              done_trap  <= 1'b0;
              done_cause <= '0;
              done_instr <= ibus_rsp_rdata;
              pc_q       <= pc_q + 32'd4;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk #(
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               ibus_req_valid,
  input logic               ibus_req_ready,
  input logic [31:0]        ibus_req_addr,
  input logic               ibus_rsp_valid,
  input logic               ibus_rsp_ready,
  input logic               ibus_rsp_err,
  input logic               done_valid,
  input logic               done_trap,
  input logic [CAUSE_W-1:0] done_cause,
  input logic [31:0]        done_pc
);

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_req_valid && !ibus_req_ready) |=> (ibus_req_valid && $stable(ibus_req_addr)));

  a_r4_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    !(ibus_req_valid && ibus_rsp_ready));

  a_r4_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibus_rsp_ready) |-> $past(ibus_req_valid && ibus_req_ready));

  a_r5_ok_from_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_trap) |-> $past(ibus_rsp_valid && ibus_rsp_ready && !ibus_rsp_err));

  a_r7_fault_from_err: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_trap && done_cause == CAUSE_W'(1))
      |-> $past(ibus_rsp_valid && ibus_rsp_ready && ibus_rsp_err));

  a_r6_misal_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_trap && done_cause == CAUSE_W'(0)) |-> (done_pc[1:0] != 2'b00));

  a_r9_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy);

endmodule

bind ifetch_unit ifetch_unit_chk #(.CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .ibus_req_valid(ibus_req_valid), .ibus_req_ready(ibus_req_ready),
  .ibus_req_addr(ibus_req_addr), .ibus_rsp_valid(ibus_rsp_valid),
  .ibus_rsp_ready(ibus_rsp_ready), .ibus_rsp_err(ibus_rsp_err),
  .done_valid(done_valid), .done_trap(done_trap),
  .done_cause(done_cause), .done_pc(done_pc)
);

// File: tb/ifetch_unit_bench.sv
`timescale 1ns/1ps
module ifetch_unit_bench;

  localparam logic [31:0] RVEC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0, redir_valid = 1'b0;
  logic [31:0] redir_pc = '0;
  logic        busy;
  logic        req_valid, req_ready, req_we;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic [3:0]  req_wstrb, req_amo;
  logic        rsp_valid, rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic        done_valid, done_trap;
  logic [3:0]  done_cause;
  logic [31:0] done_instr, done_pc;

  always #2.5 clk = ~clk;

  ifetch_unit #(.RESET_VEC(RVEC), .CAUSE_W(4)) u_ifetch_unit (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .busy(busy),
    .ibus_req_valid(req_valid), .ibus_req_ready(req_ready),
    .ibus_req_addr(req_addr), .ibus_req_we(req_we),
    .ibus_req_size(req_size), .ibus_req_wdata(req_wdata),
    .ibus_req_wstrb(req_wstrb), .ibus_req_amo(req_amo),
    .ibus_rsp_valid(rsp_valid), .ibus_rsp_ready(rsp_ready),
    .ibus_rsp_rdata(rsp_rdata), .ibus_rsp_err(rsp_err),
    .done_valid(done_valid), .done_trap(done_trap), .done_cause(done_cause),
    .done_instr(done_instr), .done_pc(done_pc)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[31:16] ^ 16'h0F0F};
  endfunction
  function automatic logic is_bad(input logic [31:0] a);
    return a[31:28] == 4'hF;
  endfunction

  // slave model
  logic [3:0]  rdly = 0, sdly = 0, wcnt, scnt;
  logic        pend;
  logic [31:0] laddr, last_addr;
  int          nreq = 0, viol_ro = 0, viol_ovl = 0;

  assign req_ready = req_valid && (wcnt == rdly);
  assign rsp_valid = pend && (scnt == sdly);
  assign rsp_err   = rsp_valid && is_bad(laddr);
  assign rsp_rdata = (rsp_valid && !is_bad(laddr)) ? mem_word(laddr) : 32'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= 0; scnt <= 0; pend <= 1'b0; laddr <= '0; last_addr <= '0;
    end else begin
      if (req_valid && !req_ready) wcnt <= wcnt + 1;
      if (req_valid && req_ready) begin
        wcnt <= 0; scnt <= 0; pend <= 1'b1; laddr <= req_addr; last_addr <= req_addr;
        nreq <= nreq + 1;
        if (req_we || req_amo != 0 || req_wstrb != 0 || req_wdata != 0 || req_size != 2'b10)
          viol_ro <= viol_ro + 1;
      end
      if (pend && !rsp_valid) scnt <= scnt + 1;
      if (rsp_valid && rsp_ready) pend <= 1'b0;
      if (req_valid && rsp_ready) viol_ovl <= viol_ovl + 1;
      if (rsp_ready && !pend) viol_ovl <= viol_ovl + 1;
    end
  end

  int nchk = 0, nfail = 0;
  logic [31:0] mpc = RVEC;

  task automatic check(input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_fetch(input logic redir, input logic [31:0] rpc,
                           input logic poke, input string tag);
    int          n0;
    logic        got;
    logic        e_trap;
    logic [3:0]  e_cause;
    logic [31:0] e_instr;
    logic        misal;
    @(negedge clk);
    if (redir) mpc = rpc;
    misal   = (mpc[1:0] != 2'b00);
    e_trap  = misal || is_bad(mpc);
    e_cause = misal ? 4'd0 : 4'd1;
    e_instr = e_trap ? 32'h0 : mem_word(mpc);
    n0 = nreq;
    fetch_req = 1'b1; redir_valid = redir; redir_pc = rpc;
    @(negedge clk);
    fetch_req = 1'b0; redir_valid = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done_valid) begin got = 1'b1; break; end
      if (poke && busy) begin
        fetch_req = 1'b1; redir_valid = 1'b1; redir_pc = 32'h0000_9000;
        @(negedge clk);
        fetch_req = 1'b0; redir_valid = 1'b0;
        poke = 1'b0;
        continue;
      end
      @(negedge clk);
    end
    check(got, {tag, " done seen"}, {31'b0, got}, 32'h1);
    check(done_trap == e_trap, {tag, " trap flag"}, {31'b0, done_trap}, {31'b0, e_trap});
    if (e_trap)
      check(done_cause == e_cause, {tag, " cause"}, {28'b0, done_cause}, {28'b0, e_cause});
    check(done_instr == e_instr, {tag, " instr"}, done_instr, e_instr);
    check(done_pc == mpc, {tag, " done_pc"}, done_pc, mpc);
    if (misal) begin
      check(nreq == n0, "R6 no request on misaligned", nreq, n0);
    end else begin
      check(nreq == n0 + 1, "R3 one request per fetch", nreq, n0 + 1);
      check(last_addr == mpc, {tag, " request address"}, last_addr, mpc);
    end
    @(negedge clk);
    check(!done_valid, {tag, " done one cycle"}, {31'b0, done_valid}, 32'h0);
    check(!busy, "R9 idle after fetch", {31'b0, busy}, 32'h0);
    if (!e_trap) mpc = mpc + 32'd4;
  endtask

  typedef struct packed {
    logic [31:0] pc;
    logic [3:0]  rd;
    logic [3:0]  sd;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h0000_2000, 4'd0, 4'd0},
    '{32'h0000_2004, 4'd2, 4'd0},
    '{32'h0000_2100, 4'd0, 4'd3},
    '{32'h0000_3002, 4'd0, 4'd0},
    '{32'hF000_0010, 4'd1, 4'd1},
    '{32'h0000_4001, 4'd1, 4'd0},
    '{32'h0000_5000, 4'd4, 4'd4},
    '{32'hF000_0020, 4'd0, 4'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done_valid && !req_valid, "R1 idle in reset",
          {29'b0, busy, done_valid, req_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done_valid && !req_valid, "R1 idle after reset",
          {29'b0, busy, done_valid, req_valid}, 32'h0);

    rdly = 0; sdly = 0;
    run_fetch(1'b0, '0, 1'b0, "R1 reset vector");
    run_fetch(1'b0, '0, 1'b0, "R5 sequential");

    for (int v = 0; v < 8; v++) begin
      rdly = VEC[v].rd; sdly = VEC[v].sd;
      if (VEC[v].pc[1:0] != 2'b00)      run_fetch(1'b1, VEC[v].pc, 1'b0, "R6 misaligned");
      else if (VEC[v].pc[31:28] == 4'hF) run_fetch(1'b1, VEC[v].pc, 1'b0, "R7 fault");
      else                               run_fetch(1'b1, VEC[v].pc, 1'b0, "R10 latency");
    end

    rdly = 2; sdly = 1;
    run_fetch(1'b0, '0, 1'b0, "R7 retry same pc");

    rdly = 5; sdly = 2;
    run_fetch(1'b1, 32'h0000_6000, 1'b1, "R8 redirect with fetch");
    rdly = 0; sdly = 0;
    run_fetch(1'b0, '0, 1'b0, "R8 busy redirect ignored");

    @(negedge clk);
    redir_valid = 1'b1; redir_pc = 32'h0000_7000;
    @(negedge clk);
    redir_valid = 1'b0;
    check(!busy && !req_valid, "R8 redirect alone starts nothing",
          {30'b0, busy, req_valid}, 32'h0);
    mpc = 32'h0000_7000;
    run_fetch(1'b0, '0, 1'b0, "R8 idle redirect");

    check(viol_ro == 0, "R2 read-only request fields", viol_ro, 0);
    check(viol_ovl == 0, "R4 response ready window", viol_ovl, 0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule